// File: doc/BRIEF.md
# Data bus inversion encoder

This block sits on the transmit side of a wide parallel bus and prepares each outgoing 64-bit beat so that fewer wires switch. The bus is split into four independent 16-bit groups. For every group the encoder counts how many bits would change level if the true data were driven as it is. The count is taken against the value that group last put on the wires, which is not the same as the last true data. When that count is more than half the group width, the group is driven inverted and its inversion flag is raised. A receiver recovers the true data by XOR-ing each group with its flag.

Alongside the data the encoder drives one parity bit per group. Each is the even parity of the 16 bits actually placed on the wires, so it is taken after any inversion, and the flag is not part of it. The wire-state register starts at all ones, the idle level of an active-low bus. It changes only when a beat is accepted.

Beats enter on a valid/ready stream and leave on a valid/ready stream through one output register. A beat is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output holds its data, flags and parity unchanged, and no new beat is taken. Strobe generation and pad timing are handled elsewhere.

Top module: `dbi_encoder`

## Requirements
- R1: The bus is handled as four groups with fixed positions: flag/parity bit g covers data bits [16g+15:16g], so flag 0 covers 15:0 and flag 3 covers 63:48; each group decides alone.
- R2: When 9 or more of a group's 16 true bits differ from that group's last driven wire value, the group is driven as the bitwise inverse of its true data and its flag is 1.
- R3: When 8 or fewer bits would change, exactly 8 included, the group is driven with its true data and its flag is 0.
- R4: Parity bit g equals the XOR of the 16 driven bits of group g (even parity over the wires, flag excluded).
- R5: After reset, out_data is all ones, all flags are 0, all parity bits are 0 and out_valid is 0.
- R6: Toggles are counted against the last driven wire value, and that value changes only on an accepted beat; a beat offered while in_ready is low has no effect on any output.
- R7: in_ready = !out_valid || out_ready; while out_valid is high and out_ready is low, out_data, out_inv and out_par stay stable and out_valid stays high.
- R8: An accepted beat appears on the outputs with out_valid high in the cycle after acceptance, and beats leave in the order they were accepted.
- R9: XOR-ing each driven group with its flag returns the true data, and no group shows more than 8 wire toggles between consecutive accepted beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | True data beat offered |
| in_ready | output | 1 | Encoder can take a beat this cycle |
| in_data | input | 64 | True (unencoded) data |
| out_valid | output | 1 | Encoded beat present |
| out_ready | input | 1 | Downstream takes the encoded beat |
| out_data | output | 64 | Driven bus value, last driven value while idle |
| out_inv | output | 4 | Per-group inversion flags |
| out_par | output | 4 | Per-group even parity of the driven bits |

## Verification
The hardest situations to reach are the two exact thresholds, 8 and 9 toggles in one group. They have to be measured against a wire state that has already been flipped by an earlier inverted beat, and random 16-bit data lands on those counts only now and then. The stimulus therefore builds directed beats from the known previous driven value: it flips exactly 8 or 9 chosen bits per group, and it follows a fully inverted beat with data that matches its true value but not its wire value. These directed beats are mixed with seeded random data and random back-pressure, so that offers made while stalled are also tested.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int unsigned BUS_W   = 64;
  localparam int unsigned GROUP_W = 16;
  localparam int unsigned N_GRP   = BUS_W / GROUP_W;
  localparam int unsigned CNT_W   = $clog2(GROUP_W + 1);

  typedef logic [GROUP_W-1:0] grp_word_t;
  typedef logic [CNT_W-1:0]   grp_cnt_t;
endpackage

// File: rtl/dbi_popcount.sv
module dbi_popcount #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/dbi_group_enc.sv
module dbi_group_enc #(
  parameter int unsigned GW = 16
) (
  input  logic [GW-1:0] true_i,
  input  logic [GW-1:0] wire_prev_i,
  output logic [GW-1:0] drive_o,
  output logic          inv_o,
  output logic          par_o
);
  localparam int unsigned CW   = $clog2(GW + 1);
  localparam int unsigned HALF = GW / 2;

  logic [GW-1:0] diff;
  logic [CW-1:0] flips;

  assign diff = true_i ^ wire_prev_i;

  dbi_popcount #(.W(GW)) u_cnt (
    .vec_i (diff),
    .cnt_o (flips)
  );

  // strictly more than half the group toggling selects inversion
  assign inv_o   = (flips > CW'(HALF));
  assign drive_o = inv_o ? ~true_i : true_i;
  assign par_o   = ^drive_o;
endmodule

// File: rtl/dbi_out_stage.sv
module dbi_out_stage #(
  parameter int unsigned NG = 4,
  parameter int unsigned GW = 16,
  localparam int unsigned BW = NG * GW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          drain_i,
  input  logic [BW-1:0] data_i,
  input  logic [NG-1:0] inv_i,
  input  logic [NG-1:0] par_i,
  output logic          valid_o,
  output logic [BW-1:0] data_o,
  output logic [NG-1:0] inv_o,
  output logic [NG-1:0] par_o
);
  // parity of an all-ones group at reset
  localparam logic PAR_IDLE = GW[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '1;
      inv_o  <= '0;
      par_o  <= {NG{PAR_IDLE}};
    end else if (load_i) begin
      data_o <= data_i;
      inv_o  <= inv_i;
      par_o  <= par_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_o <= 1'b0;
    else if (load_i)  valid_o <= 1'b1;
    else if (drain_i) valid_o <= 1'b0;
  end
endmodule

// File: rtl/dbi_encoder.sv
module dbi_encoder
  import dbi_pkg::*;
#(
  parameter int unsigned GROUPS = N_GRP,
  parameter int unsigned GW     = GROUP_W,
  localparam int unsigned BW    = GROUPS * GW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [BW-1:0] out_data,
  output logic [GROUPS-1:0] out_inv,
  output logic [GROUPS-1:0] out_par
);
  logic              accept;
  logic [BW-1:0]     drive_next;
  logic [GROUPS-1:0] inv_next;
  logic [GROUPS-1:0] par_next;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // out_data doubles as the last driven wire state of every group
  for (genvar g = 0; g < int'(GROUPS); g++) begin : g_grp
    dbi_group_enc #(.GW(GW)) u_enc (
      .true_i      (in_data[g*GW +: GW]),
      .wire_prev_i (out_data[g*GW +: GW]),
      .drive_o     (drive_next[g*GW +: GW]),
      .inv_o       (inv_next[g]),
      .par_o       (par_next[g])
    );
  end

  dbi_out_stage #(.NG(GROUPS), .GW(GW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .drain_i (out_ready),
    .data_i  (drive_next),
    .inv_i   (inv_next),
    .par_i   (par_next),
    .valid_o (out_valid),
    .data_o  (out_data),
    .inv_o   (out_inv),
    .par_o   (out_par)
  );
endmodule

// File: rtl/dbi_encoder_chk.sv
module dbi_encoder_chk #(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned GW     = 16,
  localparam int unsigned BW    = GROUPS * GW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BW-1:0]     in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BW-1:0]     out_data,
  input logic [GROUPS-1:0] out_inv,
  input logic [GROUPS-1:0] out_par
);
  localparam int HALF = int'(GW / 2);

  p_ready_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_inv) && $stable(out_par)));

  p_beat_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_no_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_data));

  for (genvar g = 0; g < int'(GROUPS); g++) begin : g_chk
    p_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=>
        ((out_data[g*GW +: GW] ^ {GW{out_inv[g]}}) == $past(in_data[g*GW +: GW])));

    p_toggle_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=>
        ($countones(out_data[g*GW +: GW] ^ $past(out_data[g*GW +: GW])) <= HALF));

    p_invert_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((in_valid && in_ready)
       && ($countones(in_data[g*GW +: GW] ^ out_data[g*GW +: GW]) > HALF))
      |=> out_inv[g]);

    p_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((in_valid && in_ready)
       && ($countones(in_data[g*GW +: GW] ^ out_data[g*GW +: GW]) <= HALF))
      |=> !out_inv[g]);

    p_even_par_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({out_par[g], out_data[g*GW +: GW]}) % 2 == 0);
  end
endmodule

bind dbi_encoder dbi_encoder_chk #(.GROUPS(GROUPS), .GW(GW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_inv   (out_inv),
  .out_par   (out_par)
);

// File: tb/dbi_encoder_tb.sv
module dbi_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic [3:0]  out_inv;
  logic [3:0]  out_par;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;

  always #2.5 clk = ~clk;

  dbi_encoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_inv(out_inv), .out_par(out_par)
  );

  typedef struct packed {
    logic [63:0] data;
    logic [3:0]  inv;
    logic [3:0]  par;
    logic [63:0] truth;
    logic [63:0] prev;
  } beat_t;

  beat_t       q[$];
  logic [63:0] model_wire;
  logic        stall_seen;
  logic [71:0] stall_snap;

  function automatic int ones16(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic beat_t encode(input logic [63:0] prev, input logic [63:0] d);
    beat_t b;
    b.truth = d;
    b.prev  = prev;
    for (int g = 0; g < 4; g++) begin
      b.inv[g] = ones16(d[g*16 +: 16] ^ prev[g*16 +: 16]) >= 9;
      b.data[g*16 +: 16] = b.inv[g] ? ~d[g*16 +: 16] : d[g*16 +: 16];
      b.par[g] = ones16(b.data[g*16 +: 16]) % 2 == 1;
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, evaluate 1 ns later, commit at next posedge
  task automatic step(input bit v, input logic [63:0] d, input bit rdy);
    beat_t e;
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = rdy;
    #1;
    if (stall_seen)
      check({out_data, out_inv, out_par} == stall_snap[71:0] && out_valid,
            "R7 hold", out_data, stall_snap[71:8]);
    check(in_ready == (!out_valid || out_ready), "R7 ready", 64'(in_ready),
          64'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(0, "R8 unexpected beat", out_data, 64'h0);
      end else begin
        e = q.pop_front();
        check(out_data == e.data, "R1/R2/R3 data", out_data, e.data);
        check(out_inv == e.inv, "R2/R3 flags", 64'(out_inv), 64'(e.inv));
        check(out_par == e.par, "R4 parity", 64'(out_par), 64'(e.par));
        for (int g = 0; g < 4; g++) begin
          check((out_data[g*16 +: 16] ^ {16{out_inv[g]}}) == e.truth[g*16 +: 16],
                "R9 decode", out_data, e.truth);
          check(ones16(out_data[g*16 +: 16] ^ e.prev[g*16 +: 16]) <= 8,
                "R9 toggle cap", out_data, e.prev);
        end
      end
    end
    stall_seen = out_valid && !out_ready;
    stall_snap = {out_data, out_inv, out_par};
    if (in_valid && in_ready) begin
      e = encode(model_wire, d);
      model_wire = e.data;
      q.push_back(e);
    end
  endtask

  task automatic send(input logic [63:0] d);
    do step(1'b1, d, 1'b1); while (!(in_valid && in_ready));
  endtask

  function automatic logic [15:0] flip_n(input logic [15:0] base, input int n);
    logic [15:0] r = base;
    for (int i = 0; i < n; i++) r[i] = ~r[i];
    return r;
  endfunction

  function automatic logic [63:0] flip_all(input logic [63:0] base, input int n);
    logic [63:0] r;
    for (int g = 0; g < 4; g++) r[g*16 +: 16] = flip_n(base[g*16 +: 16], n);
    return r;
  endfunction

  initial begin
    model_wire = '1;
    stall_seen = 1'b0;
    stall_snap = '0;
    #12;
    check(out_data == '1, "R5 reset data", out_data, '1);
    check(out_inv == 4'h0 && out_par == 4'h0 && !out_valid, "R5 reset flags",
          64'({out_inv, out_par, 3'b0, out_valid}), 64'h0);
    rst_n = 1'b1;

    // R3: exactly 8 toggles from idle -> plain
    send(flip_all('1, 8));
    // R2: exactly 9 toggles from last wire -> inverted
    send(flip_all(model_wire, 9));
    // R6: true data equals last true value but not the wire value
    send(model_wire ^ 64'hFFFF_FFFF_FFFF_FFFF);
    send(64'h0);
    // R1: only group 2 flips all bits, other groups unchanged
    send(model_wire ^ 64'h0000_FFFF_0000_0000);
    step(1'b0, '0, 1'b1);
    check(out_inv == 4'b0100, "R1 group 2 only", 64'(out_inv), 64'h4);
    send(flip_all(model_wire, 7));
    send(flip_all(model_wire, 16));

    // R6/R7/R8: random stream with back-pressure, offers while stalled
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] d;
      int mode = $urandom_range(0, 3);
      if (mode == 0) d = flip_all(model_wire, $urandom_range(7, 9));
      else d = {$urandom(), $urandom()};
      step($urandom_range(0, 3) != 0, d, $urandom_range(0, 2) != 0);
    end
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
    check(q.size() == 0, "R8 drained", 64'(q.size()), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule